// File: doc/BRIEF.md
# DRAM Cycle Type Decoder

This block sits on the strobe side of a bus-functional responder that stands in for an asynchronous multiplexed-address DRAM. It samples the row strobe, the two byte-lane column strobes, the write strobe, the output-enable strobe and the address pins on a fast system clock. From the order in which those strobes change it works out what kind of access the controller is performing. It latches the row and column addresses. It keeps the internal refresh row counter. It issues one-clock read, write and refresh strobes to a behavioural storage model, and it tells the pad logic when each byte lane may drive the data bus.

Every pin passes through two sampling registers. A change applied between clock edges k-1 and k is seen as an edge at edge k, and the resulting state, strobes and addresses appear on the outputs after edge k+1. The sequencer has nine states. IDLE means the row strobe is high. ROW means a row is open and no column has been seen. READ, EWRITE and RMW are the column access states. RONLY is a one-clock refresh report. CBR means a counter refresh is under way. RDHOLD means the row strobe is high while read data is held. HIDDEN means a counter refresh is taken under held read data.

The transitions are as follows:
- IDLE or RONLY goes to CBR on a row fall with a column strobe low, and to ROW on a row fall with both column strobes high. RONLY otherwise returns to IDLE.
- ROW goes to RONLY on a row rise, and to READ or EWRITE on a column fall.
- READ or RMW goes to RMW on a write fall while a column strobe is low. A page column fall sends it to READ or EWRITE. A row rise sends it to RDHOLD if a column strobe is still low, and to IDLE otherwise.
- EWRITE and CBR return to IDLE on a row rise. EWRITE also changes on a page column fall.
- RDHOLD goes to HIDDEN on a row fall with a column strobe low, and to IDLE when both column strobes go high.
- HIDDEN goes to RDHOLD or IDLE on a row rise.

Top module: `dram_cycle_decoder`

## Requirements
- R1: While reset is asserted, and until a strobe edge has been seen, cycle_type is 0 (idle). All strobes and both lane enables are 0. row_addr, col_addr and ref_row are 0, and the refresh counter holds 0.
- R2: A row strobe fall with both column strobes high latches addr into row_addr. Each later column strobe fall (either lane, repeated in page mode) latches addr into col_addr and gives a one-clock col_stb. All outputs change two clocks after the pin change.
- R3: A column strobe fall with the write strobe high makes cycle_type 1 (read) and pulses rd_stb_hi or rd_stb_lo for each lane (upper, lower) whose strobe fell.
- R4: A column strobe fall with the write strobe low makes cycle_type 2 (early write) and pulses wr_stb_hi or wr_stb_lo for each falling lane. Both lane enables stay 0 for the whole cycle, even with output enable low.
- R5: A write strobe fall during a read, while a column strobe is low, makes cycle_type 3 (read-modify-write) and pulses the write strobe of every lane whose column strobe is low.
- R6: dq_oe_hi (dq_oe_lo) is 1 only in a read, read-modify-write or held-read state while the upper (lower) column strobe and the output enable are both low. It drops when either one rises.
- R7: A row strobe low period with both column strobes high throughout gives, after the rise, one clock of cycle_type 4 together with ref_stb and ref_row equal to the latched row.
- R8: A row strobe fall with a column strobe already low makes cycle_type 5 (counter refresh). It pulses ref_stb with ref_row equal to the counter, then advances the counter. The address pins are ignored and row_addr keeps its previous value.
- R9: After a read, holding a column strobe low while the row strobe rises and falls again makes cycle_type 6 (hidden refresh). It pulses ref_stb with the counter value and advances the counter, and the lane enables keep driving throughout.
- R10: The refresh counter advances by one per counter refresh (R8, R9) and wraps from 511 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| ucas_n | input | 1 | Upper-lane column strobe, active low |
| lcas_n | input | 1 | Lower-lane column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| cycle_type | output | 3 | 0 idle, 1 read, 2 early write, 3 read-modify-write, 4 row-only refresh, 5 counter refresh, 6 hidden refresh |
| row_addr | output | ADDR_W | Latched row |
| col_addr | output | ADDR_W | Latched column |
| col_stb | output | 1 | One-clock pulse per column event |
| rd_stb_hi | output | 1 | Upper-lane read pulse |
| rd_stb_lo | output | 1 | Lower-lane read pulse |
| wr_stb_hi | output | 1 | Upper-lane write pulse |
| wr_stb_lo | output | 1 | Lower-lane write pulse |
| ref_stb | output | 1 | One-clock refresh pulse |
| ref_row | output | ADDR_W | Row refreshed by the last ref_stb |
| dq_oe_hi | output | 1 | Upper-lane bus drive enable |
| dq_oe_lo | output | 1 | Lower-lane bus drive enable |

## Verification
The bench goes after the orderings that tell cycles apart. Column low before the row fall must give a counter refresh; a design that tested levels instead of order would open a normal row and overwrite row_addr with the pin address. Write low at the column fall must give an early write with the bus kept quiet; one that looked only at output enable would drive the lanes. A write fall after a single-lane read must write only that lane, and a row strobe rising and falling again under a held column strobe must refresh from the counter without dropping the lane enables. Page-mode column falls, lane-split reads and 512-plus counter refreshes check the per-event column latch and the counter wrap to 0.

// File: rtl/dcd_pkg.sv
package dcd_pkg;

    typedef enum logic [2:0] {
        CT_IDLE   = 3'd0,
        CT_READ   = 3'd1,
        CT_EWRITE = 3'd2,
        CT_RMW    = 3'd3,
        CT_RONLY  = 3'd4,
        CT_CBR    = 3'd5,
        CT_HIDDEN = 3'd6
    } cyc_code_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ROW,
        ST_READ,
        ST_EWRITE,
        ST_RMW,
        ST_RONLY,
        ST_CBR,
        ST_RDHOLD,
        ST_HIDDEN
    } fsm_state_e;

    typedef struct packed {
        logic ras_n;
        logic ucas_n;
        logic lcas_n;
        logic we_n;
        logic oe_n;
    } pin_lvl_t;

    typedef struct packed {
        logic ras_fall;
        logic ras_rise;
        logic ucas_fall;
        logic lcas_fall;
        logic we_fall;
    } pin_evt_t;

    typedef struct packed {
        logic ucas_low;
        logic lcas_low;
        logic we_low;
        logic hi_drive_ok;
        logic lo_drive_ok;
    } pin_view_t;

    typedef struct packed {
        logic col;
        logic rd_hi;
        logic rd_lo;
        logic wr_hi;
        logic wr_lo;
        logic refr;
    } strobe_t;

endpackage

// File: rtl/dcd_pin_sampler.sv
module dcd_pin_sampler
    import dcd_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_n,
    input  logic              ucas_n,
    input  logic              lcas_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_now,
    output pin_evt_t          evt,
    output pin_view_t         view
);

    pin_lvl_t now_q;
    pin_lvl_t old_q;
    pin_lvl_t pins;

    assign pins = '{ras_n: ras_n, ucas_n: ucas_n, lcas_n: lcas_n,
                    we_n: we_n, oe_n: oe_n};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            now_q    <= '1;
            old_q    <= '1;
            addr_now <= '0;
        end else begin
            old_q    <= now_q;
            now_q    <= pins;
            addr_now <= addr_in;
        end
    end

    always_comb begin
        evt.ras_fall  = old_q.ras_n  & ~now_q.ras_n;
        evt.ras_rise  = ~old_q.ras_n & now_q.ras_n;
        evt.ucas_fall = old_q.ucas_n & ~now_q.ucas_n;
        evt.lcas_fall = old_q.lcas_n & ~now_q.lcas_n;
        evt.we_fall   = old_q.we_n   & ~now_q.we_n;

        view.ucas_low    = ~now_q.ucas_n;
        view.lcas_low    = ~now_q.lcas_n;
        view.we_low      = ~now_q.we_n;
        // aligned with the sequencer state, which lags the sample by one edge
        view.hi_drive_ok = ~old_q.ucas_n & ~old_q.oe_n;
        view.lo_drive_ok = ~old_q.lcas_n & ~old_q.oe_n;
    end

endmodule

// File: rtl/dcd_refresh_ctr.sv
module dcd_refresh_ctr #(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    output logic [CNT_W-1:0] cnt
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (adv) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/dcd_cycle_fsm.sv
module dcd_cycle_fsm
    import dcd_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  pin_evt_t          evt,
    input  pin_view_t         view,
    input  logic [ADDR_W-1:0] addr_now,
    input  logic [ADDR_W-1:0] ref_cnt,
    output logic              ref_adv,
    output logic [2:0]        cycle_type,
    output logic [ADDR_W-1:0] row_addr,
    output logic [ADDR_W-1:0] col_addr,
    output strobe_t           stb,
    output logic [ADDR_W-1:0] ref_row,
    output logic              dq_oe_hi,
    output logic              dq_oe_lo
);

    fsm_state_e        st_q, st_d;
    logic [ADDR_W-1:0] row_q, row_d;
    logic [ADDR_W-1:0] col_q, col_d;
    logic [ADDR_W-1:0] rref_q, rref_d;
    strobe_t           stb_q, stb_d;
    logic              cas_low;
    logic              cas_fall;
    logic              open_col;
    logic              take_cnt;

    assign cas_low  = view.ucas_low | view.lcas_low;
    assign cas_fall = evt.ucas_fall | evt.lcas_fall;

    always_comb begin
        st_d     = st_q;
        row_d    = row_q;
        col_d    = col_q;
        rref_d   = rref_q;
        stb_d    = '0;
        open_col = 1'b0;
        take_cnt = 1'b0;
        ref_adv  = 1'b0;

        unique case (st_q)
            ST_IDLE, ST_RONLY: begin
                st_d = ST_IDLE;
                if (evt.ras_fall) begin
                    if (cas_low) begin
                        st_d     = ST_CBR;
                        take_cnt = 1'b1;
                    end else begin
                        st_d  = ST_ROW;
                        row_d = addr_now;
                    end
                end
            end
            ST_ROW: begin
                if (evt.ras_rise) begin
                    st_d      = ST_RONLY;
                    stb_d.refr = 1'b1;
                    rref_d    = row_q;
                end else if (cas_fall) begin
                    open_col = 1'b1;
                end
            end
            ST_READ, ST_RMW: begin
                if (evt.ras_rise) begin
                    st_d = cas_low ? ST_RDHOLD : ST_IDLE;
                end else if (cas_fall) begin
                    open_col = 1'b1;
                end else if (evt.we_fall && cas_low) begin
                    st_d        = ST_RMW;
                    stb_d.wr_hi = view.ucas_low;
                    stb_d.wr_lo = view.lcas_low;
                end
            end
            ST_EWRITE: begin
                if (evt.ras_rise) begin
                    st_d = ST_IDLE;
                end else if (cas_fall) begin
                    open_col = 1'b1;
                end
            end
            ST_CBR: begin
                if (evt.ras_rise) begin
                    st_d = ST_IDLE;
                end
            end
            ST_RDHOLD: begin
                if (evt.ras_fall) begin
                    if (cas_low) begin
                        st_d     = ST_HIDDEN;
                        take_cnt = 1'b1;
                    end else begin
                        st_d  = ST_ROW;
                        row_d = addr_now;
                    end
                end else if (!cas_low) begin
                    st_d = ST_IDLE;
                end
            end
            ST_HIDDEN: begin
                if (evt.ras_rise) begin
                    st_d = cas_low ? ST_RDHOLD : ST_IDLE;
                end
            end
            default: st_d = ST_IDLE;
        endcase

        if (open_col) begin
            col_d     = addr_now;
            stb_d.col = 1'b1;
            if (view.we_low) begin
                st_d        = ST_EWRITE;
                stb_d.wr_hi = evt.ucas_fall;
                stb_d.wr_lo = evt.lcas_fall;
            end else begin
                st_d        = ST_READ;
                stb_d.rd_hi = evt.ucas_fall;
                stb_d.rd_lo = evt.lcas_fall;
            end
        end

        if (take_cnt) begin
            stb_d.refr = 1'b1;
            rref_d     = ref_cnt;
            ref_adv    = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            row_q  <= '0;
            col_q  <= '0;
            rref_q <= '0;
            stb_q  <= '0;
        end else begin
            st_q   <= st_d;
            row_q  <= row_d;
            col_q  <= col_d;
            rref_q <= rref_d;
            stb_q  <= stb_d;
        end
    end

    always_comb begin
        cyc_code_e code;
        logic      drives;
        unique case (st_q)
            ST_READ:   begin code = CT_READ;   drives = 1'b1; end
            ST_RDHOLD: begin code = CT_READ;   drives = 1'b1; end
            ST_EWRITE: begin code = CT_EWRITE; drives = 1'b0; end
            ST_RMW:    begin code = CT_RMW;    drives = 1'b1; end
            ST_RONLY:  begin code = CT_RONLY;  drives = 1'b0; end
            ST_CBR:    begin code = CT_CBR;    drives = 1'b0; end
            ST_HIDDEN: begin code = CT_HIDDEN; drives = 1'b1; end
            default:   begin code = CT_IDLE;   drives = 1'b0; end
        endcase
        cycle_type = code;
        dq_oe_hi   = drives & view.hi_drive_ok;
        dq_oe_lo   = drives & view.lo_drive_ok;
        row_addr   = row_q;
        col_addr   = col_q;
        ref_row    = rref_q;
        stb        = stb_q;
    end

endmodule

// File: rtl/dram_cycle_decoder.sv
module dram_cycle_decoder
    import dcd_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_n,
    input  logic              ucas_n,
    input  logic              lcas_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    output logic [2:0]        cycle_type,
    output logic [ADDR_W-1:0] row_addr,
    output logic [ADDR_W-1:0] col_addr,
    output logic              col_stb,
    output logic              rd_stb_hi,
    output logic              rd_stb_lo,
    output logic              wr_stb_hi,
    output logic              wr_stb_lo,
    output logic              ref_stb,
    output logic [ADDR_W-1:0] ref_row,
    output logic              dq_oe_hi,
    output logic              dq_oe_lo
);

    localparam int CNT_W = ADDR_W;

    logic [ADDR_W-1:0] addr_now;
    pin_evt_t          evt;
    pin_view_t         view;
    logic [CNT_W-1:0]  ref_cnt;
    logic              ref_adv;
    strobe_t           stb;

    dcd_pin_sampler #(.ADDR_W(ADDR_W)) u_sampler (
        .clk      (clk),
        .rst_n    (rst_n),
        .ras_n    (ras_n),
        .ucas_n   (ucas_n),
        .lcas_n   (lcas_n),
        .we_n     (we_n),
        .oe_n     (oe_n),
        .addr_in  (addr),
        .addr_now (addr_now),
        .evt      (evt),
        .view     (view)
    );

    dcd_refresh_ctr #(.CNT_W(CNT_W)) u_refctr (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (ref_adv),
        .cnt   (ref_cnt)
    );

    dcd_cycle_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt        (evt),
        .view       (view),
        .addr_now   (addr_now),
        .ref_cnt    (ref_cnt),
        .ref_adv    (ref_adv),
        .cycle_type (cycle_type),
        .row_addr   (row_addr),
        .col_addr   (col_addr),
        .stb        (stb),
        .ref_row    (ref_row),
        .dq_oe_hi   (dq_oe_hi),
        .dq_oe_lo   (dq_oe_lo)
    );

    assign col_stb   = stb.col;
    assign rd_stb_hi = stb.rd_hi;
    assign rd_stb_lo = stb.rd_lo;
    assign wr_stb_hi = stb.wr_hi;
    assign wr_stb_lo = stb.wr_lo;
    assign ref_stb   = stb.refr;

endmodule

// File: rtl/dcd_checker.sv
module dcd_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       ucas_n,
    input logic       lcas_n,
    input logic       oe_n,
    input logic [2:0] cycle_type,
    input logic       col_stb,
    input logic       rd_stb_hi,
    input logic       rd_stb_lo,
    input logic       wr_stb_hi,
    input logic       wr_stb_lo,
    input logic       ref_stb,
    input logic       dq_oe_hi,
    input logic       dq_oe_lo
);

    assert_oe_hi_lane_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe_hi |-> (!$past(ucas_n, 2) && !$past(oe_n, 2)));

    assert_oe_lo_lane_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe_lo |-> (!$past(lcas_n, 2) && !$past(oe_n, 2)));

    assert_ewrite_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_type == 3'd2) |-> (!dq_oe_hi && !dq_oe_lo));

    assert_rd_type_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb_hi || rd_stb_lo) |-> (cycle_type == 3'd1));

    assert_wr_type_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb_hi || wr_stb_lo) |-> (cycle_type == 3'd2 || cycle_type == 3'd3));

    assert_rmw_from_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_type == 3'd3 && $past(cycle_type) != 3'd3) |-> ($past(cycle_type) == 3'd1));

    assert_col_has_lane_R2: assert property (@(posedge clk) disable iff (!rst_n)
        col_stb |-> (rd_stb_hi || rd_stb_lo || wr_stb_hi || wr_stb_lo));

    assert_ref_type_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ref_stb |-> (cycle_type == 3'd4 || cycle_type == 3'd5 || cycle_type == 3'd6));

    assert_ronly_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_type == 3'd4) |-> ref_stb);

endmodule

bind dram_cycle_decoder dcd_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ucas_n     (ucas_n),
    .lcas_n     (lcas_n),
    .oe_n       (oe_n),
    .cycle_type (cycle_type),
    .col_stb    (col_stb),
    .rd_stb_hi  (rd_stb_hi),
    .rd_stb_lo  (rd_stb_lo),
    .wr_stb_hi  (wr_stb_hi),
    .wr_stb_lo  (wr_stb_lo),
    .ref_stb    (ref_stb),
    .dq_oe_hi   (dq_oe_hi),
    .dq_oe_lo   (dq_oe_lo)
);

// File: tb/dram_cycle_decoder_tb.sv
module dram_cycle_decoder_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       b_ras = 1'b1, b_uc = 1'b1, b_lc = 1'b1, b_we = 1'b1, b_oe = 1'b1;
    logic [8:0] b_addr = 9'd0;

    logic [2:0] cycle_type;
    logic [8:0] row_addr, col_addr, ref_row;
    logic       col_stb, rd_stb_hi, rd_stb_lo, wr_stb_hi, wr_stb_lo, ref_stb;
    logic       dq_oe_hi, dq_oe_lo;

    always #10 clk = ~clk;

    dram_cycle_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .ras_n(b_ras), .ucas_n(b_uc), .lcas_n(b_lc),
        .we_n(b_we), .oe_n(b_oe), .addr(b_addr), .cycle_type(cycle_type),
        .row_addr(row_addr), .col_addr(col_addr), .col_stb(col_stb),
        .rd_stb_hi(rd_stb_hi), .rd_stb_lo(rd_stb_lo), .wr_stb_hi(wr_stb_hi),
        .wr_stb_lo(wr_stb_lo), .ref_stb(ref_stb), .ref_row(ref_row),
        .dq_oe_hi(dq_oe_hi), .dq_oe_lo(dq_oe_lo)
    );

    int    n_tot = 0;
    int    n_bad = 0;
    string cur_req = "R1";
    bit    cmp_on = 0;
    bit    finished = 0;

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tot++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    // phases: 0 idle,1 row open,2 read,3 early write,4 rmw,5 row-only report,
    //         6 counter refresh,7 held read,8 hidden refresh
    int  m_ph;
    bit  mp_r, mp_u, mp_l, mp_w, mp_o;
    bit  ms_r, ms_u, ms_l, ms_w, ms_o;
    int  ms_a;
    int  m_cnt;
    int  e_row, e_col, e_rrow;
    bit  e_cs, e_rh, e_rl, e_wh, e_wl, e_ref;

    function automatic int type_of(input int ph);
        case (ph)
            2, 7: return 1;
            3: return 2;
            4: return 3;
            5: return 4;
            6: return 5;
            8: return 6;
            default: return 0;
        endcase
    endfunction

    function automatic bit drives(input int ph);
        return (ph == 2 || ph == 4 || ph == 7 || ph == 8);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_cnt = 0; e_row = 0; e_col = 0; e_rrow = 0;
            {e_cs, e_rh, e_rl, e_wh, e_wl, e_ref} = '0;
            {mp_r, mp_u, mp_l, mp_w, mp_o} = '1;
            {ms_r, ms_u, ms_l, ms_w, ms_o} = '1;
            ms_a = 0;
        end else begin
            bit rf, rr, uf, lf, wf, casl, colev, cntev;
            int nx;
            rf = mp_r && !ms_r;  rr = !mp_r && ms_r;
            uf = mp_u && !ms_u;  lf = mp_l && !ms_l;  wf = mp_w && !ms_w;
            casl = !ms_u || !ms_l;
            {e_cs, e_rh, e_rl, e_wh, e_wl, e_ref} = '0;
            colev = 0; cntev = 0; nx = m_ph;
            if (m_ph == 0 || m_ph == 5) begin
                nx = 0;
                if (rf) begin
                    if (casl) begin nx = 6; cntev = 1; end
                    else begin nx = 1; e_row = ms_a; end
                end
            end else if (m_ph == 1) begin
                if (rr) begin nx = 5; e_ref = 1; e_rrow = e_row; end
                else if (uf || lf) colev = 1;
            end else if (m_ph == 2 || m_ph == 4) begin
                if (rr) nx = casl ? 7 : 0;
                else if (uf || lf) colev = 1;
                else if (wf && casl) begin nx = 4; e_wh = !ms_u; e_wl = !ms_l; end
            end else if (m_ph == 3) begin
                if (rr) nx = 0;
                else if (uf || lf) colev = 1;
            end else if (m_ph == 6) begin
                if (rr) nx = 0;
            end else if (m_ph == 7) begin
                if (rf) begin
                    if (casl) begin nx = 8; cntev = 1; end
                    else begin nx = 1; e_row = ms_a; end
                end else if (!casl) nx = 0;
            end else if (m_ph == 8) begin
                if (rr) nx = casl ? 7 : 0;
            end
            if (colev) begin
                e_col = ms_a; e_cs = 1;
                if (!ms_w) begin nx = 3; e_wh = uf; e_wl = lf; end
                else begin nx = 2; e_rh = uf; e_rl = lf; end
            end
            if (cntev) begin
                e_ref = 1; e_rrow = m_cnt; m_cnt = (m_cnt + 1) % 512;
            end
            m_ph = nx;
            {mp_r, mp_u, mp_l, mp_w, mp_o} = {ms_r, ms_u, ms_l, ms_w, ms_o};
            {ms_r, ms_u, ms_l, ms_w, ms_o} = {b_ras, b_uc, b_lc, b_we, b_oe};
            ms_a = int'(b_addr);
        end
    end

    // ---------------- per-clock comparison and refresh monitor ----------------
    int n_cref = 0;
    int prev_cref = -1;
    bit seen_wrap = 0;
    int last_ronly = -1;

    always @(negedge clk) begin
        if (cmp_on) begin
            chk(cur_req, "cycle_type", 32'(cycle_type), 32'(type_of(m_ph)));
            chk(cur_req, "row_addr", 32'(row_addr), 32'(e_row));
            chk(cur_req, "col_addr", 32'(col_addr), 32'(e_col));
            chk(cur_req, "col_stb", 32'(col_stb), 32'(e_cs));
            chk(cur_req, "rd_stb", 32'({rd_stb_hi, rd_stb_lo}), 32'({e_rh, e_rl}));
            chk(cur_req, "wr_stb", 32'({wr_stb_hi, wr_stb_lo}), 32'({e_wh, e_wl}));
            chk(cur_req, "ref_stb", 32'(ref_stb), 32'(e_ref));
            chk(cur_req, "ref_row", 32'(ref_row), 32'(e_rrow));
            chk(cur_req, "dq_oe_hi", 32'(dq_oe_hi), 32'(drives(m_ph) && !mp_u && !mp_o));
            chk(cur_req, "dq_oe_lo", 32'(dq_oe_lo), 32'(drives(m_ph) && !mp_l && !mp_o));
            if (ref_stb && cycle_type != 3'd4) begin
                // R10: counter-sourced refreshes walk 0,1,..,511,0,..
                chk("R10", "counter row", 32'(ref_row), 32'(n_cref % 512));
                if (ref_row == 9'd0 && prev_cref == 511) seen_wrap = 1;
                prev_cref = int'(ref_row);
                n_cref++;
            end
            if (ref_stb && cycle_type == 3'd4) last_ronly = int'(ref_row);
        end
    end

    // ---------------- stimulus ----------------
    task automatic drv(input bit r, input bit u, input bit l, input bit w,
                       input bit o, input int a);
        @(negedge clk);
        b_ras = r; b_uc = u; b_lc = l; b_we = w; b_oe = o; b_addr = a[8:0];
    endtask

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic st(input bit r, input bit u, input bit l, input bit w,
                      input bit o, input int a);
        drv(r, u, l, w, o, a);
        hold(3);
    endtask

    initial begin
        rst_n = 1'b0;
        hold(3);
        // R1: reset state
        chk("R1", "type in reset", 32'(cycle_type), 32'd0);
        chk("R1", "strobes in reset",
            32'({col_stb, rd_stb_hi, rd_stb_lo, wr_stb_hi, wr_stb_lo, ref_stb}), 32'd0);
        chk("R1", "oe in reset", 32'({dq_oe_hi, dq_oe_lo}), 32'd0);
        chk("R1", "addrs in reset", 32'({row_addr, col_addr, ref_row}), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        cmp_on = 1;
        hold(3);

        // R2/R3/R6: full-width read, then page access on the upper lane only
        cur_req = "R2";
        st(0, 1, 1, 1, 1, 9'h055);
        st(0, 1, 1, 1, 0, 9'h1A3);
        cur_req = "R3";
        st(0, 0, 0, 1, 0, 9'h1A3);
        chk("R3", "read type", 32'(cycle_type), 32'd1);
        chk("R6", "both lanes drive", 32'({dq_oe_hi, dq_oe_lo}), 32'h3);
        cur_req = "R6";
        st(0, 1, 1, 1, 0, 9'h0F0);
        chk("R6", "lanes off on cas rise", 32'({dq_oe_hi, dq_oe_lo}), 32'h0);
        st(0, 0, 1, 1, 0, 9'h0F0);
        chk("R2", "page column", 32'(col_addr), 32'h0F0);
        chk("R2", "row kept", 32'(row_addr), 32'h055);
        chk("R6", "upper only", 32'({dq_oe_hi, dq_oe_lo}), 32'h2);
        st(0, 0, 1, 1, 1, 9'h0F0);
        chk("R6", "oe rise stops drive", 32'({dq_oe_hi, dq_oe_lo}), 32'h0);
        st(0, 1, 1, 1, 1, 9'h0F0);
        st(1, 1, 1, 1, 1, 9'h000);

        // R4: early write with output enable low
        cur_req = "R4";
        st(0, 1, 1, 1, 1, 9'h120);
        st(0, 1, 1, 0, 0, 9'h033);
        st(0, 0, 0, 0, 0, 9'h033);
        chk("R4", "early write type", 32'(cycle_type), 32'd2);
        chk("R4", "bus quiet", 32'({dq_oe_hi, dq_oe_lo}), 32'h0);
        st(0, 1, 1, 0, 0, 9'h033);
        st(1, 1, 1, 1, 1, 9'h000);

        // R5: lower-lane read, then write strobe falls
        cur_req = "R5";
        st(0, 1, 1, 1, 1, 9'h0AA);
        st(0, 1, 0, 1, 0, 9'h011);
        chk("R3", "lane read type", 32'(cycle_type), 32'd1);
        st(0, 1, 0, 0, 0, 9'h011);
        chk("R5", "rmw type", 32'(cycle_type), 32'd3);
        st(0, 1, 0, 0, 1, 9'h011);
        st(1, 1, 1, 1, 1, 9'h000);

        // R7: row-only refresh
        cur_req = "R7";
        st(1, 1, 1, 1, 1, 9'h1FF);
        st(0, 1, 1, 1, 1, 9'h1FF);
        st(1, 1, 1, 1, 1, 9'h000);
        chk("R7", "row-only refreshed row", 32'(last_ronly), 32'h1FF);

        // R8: column low before row fall, address pins changed
        cur_req = "R8";
        st(1, 0, 0, 1, 1, 9'h0C3);
        st(0, 0, 0, 1, 1, 9'h0C3);
        chk("R8", "counter refresh type", 32'(cycle_type), 32'd5);
        chk("R8", "row untouched", 32'(row_addr), 32'h1FF);
        st(1, 0, 0, 1, 1, 9'h0C3);
        st(1, 1, 1, 1, 1, 9'h000);

        // R9: hidden refresh under held read data
        cur_req = "R9";
        st(0, 1, 1, 1, 1, 9'h077);
        st(0, 0, 0, 1, 0, 9'h045);
        st(1, 0, 0, 1, 0, 9'h045);
        chk("R9", "held drive", 32'({dq_oe_hi, dq_oe_lo}), 32'h3);
        st(0, 0, 0, 1, 0, 9'h045);
        chk("R9", "hidden type", 32'(cycle_type), 32'd6);
        chk("R9", "drive during refresh", 32'({dq_oe_hi, dq_oe_lo}), 32'h3);
        st(1, 0, 0, 1, 0, 9'h045);
        st(1, 1, 1, 1, 1, 9'h000);

        // R10: run the counter past its wrap
        cur_req = "R10";
        for (int i = 0; i < 512; i++) begin
            drv(1, 0, 0, 1, 1, i); hold(2);
            drv(0, 0, 0, 1, 1, i); hold(2);
            drv(1, 0, 0, 1, 1, i); hold(2);
            drv(1, 1, 1, 1, 1, i); hold(2);
        end
        hold(3);
        chk("R10", "counter refresh count", 32'(n_cref), 32'd514);
        chk("R10", "wrap seen", 32'(seen_wrap), 32'd1);

        finished = 1;
        $display("test done: total=%0d bad=%0d", n_tot, n_bad);
        $finish;
    end

    initial begin
        repeat (60000) @(posedge clk);
        if (!finished) begin
            n_tot++;
            n_bad++;
            $display("FAIL watchdog %s actual=hung expected=done", cur_req);
            $display("test done: total=%0d bad=%0d", n_tot, n_bad);
            $finish;
        end
    end

endmodule